// File: doc/BRIEF.md
# Waveform Timer/Counter

An 8-bit timer/counter with one compare channel and one waveform output. It runs in one of four counting modes: free-running, clear-on-compare, single-slope PWM and dual-slope (phase-correct) PWM. The mode decides the counter's TOP value and when a new compare value takes effect. It also decides where the overflow event falls and how the waveform output reacts to a compare match. Counting advances only on tick enables supplied from outside. A three-bit clock-select field picks which tick enable drives the counter, and zero stops it.

Software reaches the block through a plain register port. A write strobe carries an address and data. A combinational read mux returns the control word, the live count or the buffered compare value. The register port and the tick inputs are plain control pins, with no valid/ready handshake and no back-pressure. A write is accepted in every cycle that `wr_en` is high, and a read is valid in the same cycle that `rd_addr` is presented. The overflow and compare results are one-cycle event pulses. The waveform output comes with an ownership signal and a pin-drive enable that is gated by an external direction enable.

Top module: `wavetimer`

## Requirements
- R1: After reset the counter, compare register, control word, waveform output and both event pulses are 0, and the counter direction is up.
- R2: Addresses are 0 = control, 1 = counter, 2 = compare. Control bits: [7] force strobe, [6] mode low bit, [5:4] output action, [3] mode high bit, [2:0] clock select. Reading the control word returns bit 7 as 0.
- R3: Mode 0 (free-running) counts up and wraps from 0xFF to 0. A compare write takes effect at once. `ovf_flag` pulses after the tick taken at 0xFF.
- R4: Mode 2 (clear-on-compare) takes TOP from the compare value. The tick that matches it loads 0, and a compare write takes effect at once.
- R5: Mode 3 (single-slope PWM) wraps at 0xFF. A new compare value is adopted on the tick from 0xFF to 0, and `ovf_flag` pulses after that tick. With action 10 the output sets on that tick and clears on a match; action 11 inverts both. On the tick from 0xFF to 0, if a match falls on the same tick, the set/clear at BOTTOM wins.
- R6: Mode 1 (phase-correct PWM) counts 0 up to 0xFF and back down, holding each extreme for one tick. A new compare value is adopted on the tick that reaches 0xFF, and `ovf_flag` pulses after the tick that reaches 0. With action 10 a match clears the output while rising and sets it while falling; action 11 inverts this. At 0xFF the direction is already falling.
- R7: In modes 0 and 2 a compare match applies the output action: 01 toggles, 10 clears, 11 sets, 00 leaves the output alone.
- R8: A control write with bit 7 set applies the written action bits to the output at once, but only when the written mode is 0 or 2. It never raises `cmp_flag` and never clears the counter.
- R9: `wave_own` is high whenever the action bits are nonzero. `pin_en` is high only when `wave_own` and `dir_en` are both high.
- R10: Clock select 000 stops the counter. A value k in 1..7 advances it once per cycle in which `tick_in[k-1]` is high.
- R11: A counter write wins over a tick in the same cycle. The next tick after it produces no compare match.
- R12: `cmp_flag` pulses for one cycle after each tick taken while the counter equals the active compare value (unless suppressed by R11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 counter, 2 compare) |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | W | Combinational read data |
| tick_in | input | 7 | Tick enables, selected by clock select |
| dir_en | input | 1 | External direction enable for the pin |
| wave_out | output | 1 | Waveform output |
| wave_own | output | 1 | Waveform output owns the pin |
| pin_en | output | 1 | Pin driver enable |
| ovf_flag | output | 1 | One-cycle overflow event |
| cmp_flag | output | 1 | One-cycle compare-match event |

## Verification
The counter, waveform output and both event pulses are registered. Each responds to the inputs of a cycle one clock edge later. The read port is combinational and reflects the registers in the cycle it is addressed. The bench drives each vector 1 ns after a rising edge and compares all registered results 1 ns after the following rising edge, so every vector line holds the results due from that one cycle of input. Reads, the pin enables and the stop/select checks are sampled the same way, at least one edge after the write that changed them.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    WM_NORMAL = 2'd0,
    WM_PHASE  = 2'd1,
    WM_CLRCMP = 2'd2,
    WM_FAST   = 2'd3
  } wt_mode_e;

  localparam int CSW   = 3;
  localparam int NTICK = (1 << CSW) - 1;

  localparam int B_FORCE = 7;
  localparam int B_MODE0 = 6;
  localparam int B_ACT1  = 5;
  localparam int B_ACT0  = 4;
  localparam int B_MODE1 = 3;

  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_CMP = 2'd2;

  function automatic logic is_pwm(wt_mode_e m);
    return (m == WM_PHASE) || (m == WM_FAST);
  endfunction
endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl import wt_pkg::*; #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic           top_evt,
  input  logic           bot_evt,
  output wt_mode_e       mode,
  output logic [1:0]     act,
  output logic [CSW-1:0] csel,
  output logic           force_stb,
  output logic [1:0]     force_act,
  output logic           cnt_wr,
  output logic [W-1:0]   cmp_buf,
  output logic [W-1:0]   cmp_live
);
  logic     ctl_wr;
  logic     cmp_wr;
  logic     pwm_load;
  wt_mode_e new_mode;

  always_comb begin
    ctl_wr    = wr_en && (wr_addr == A_CTL);
    cmp_wr    = wr_en && (wr_addr == A_CMP);
    cnt_wr    = wr_en && (wr_addr == A_CNT);
    new_mode  = wt_mode_e'({wr_data[B_MODE1], wr_data[B_MODE0]});
    force_act = wr_data[B_ACT1:B_ACT0];
    // strobe only acts when the mode being written is a non-PWM one
    force_stb = ctl_wr && wr_data[B_FORCE] && !is_pwm(new_mode);
    pwm_load  = ((mode == WM_PHASE) && top_evt) || ((mode == WM_FAST) && bot_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= WM_NORMAL;
      act      <= '0;
      csel     <= '0;
      cmp_buf  <= '0;
      cmp_live <= '0;
    end else begin
      if (ctl_wr) begin
        mode <= new_mode;
        act  <= force_act;
        csel <= wr_data[CSW-1:0];
      end
      if (cmp_wr) cmp_buf <= wr_data;
      if (!is_pwm(mode)) cmp_live <= cmp_wr ? wr_data : cmp_buf;
      else if (pwm_load) cmp_live <= cmp_buf;
    end
  end
endmodule

// File: rtl/wt_count.sv
module wt_count import wt_pkg::*; #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wt_mode_e         mode,
  input  logic [CSW-1:0]   csel,
  input  logic [NTICK-1:0] tick_in,
  input  logic             cnt_wr,
  input  logic [W-1:0]     wr_data,
  input  logic [W-1:0]     cmp_live,
  output logic [W-1:0]     cnt,
  output logic             rising,
  output logic             hit,
  output logic             top_evt,
  output logic             bot_evt,
  output logic             ovf_q,
  output logic             cmp_q
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [NTICK:0] tick_ext;
  logic           tick_ok;
  logic           sup_q;
  logic           at_max;
  logic           ovf_evt;
  logic [W-1:0]   nxt;

  always_comb begin
    tick_ext = {tick_in, 1'b0};          // select 0 maps to a constant 0
    tick_ok  = tick_ext[csel] && !cnt_wr;
    at_max   = (cnt == MAXV);
    hit      = tick_ok && !sup_q && (cnt == cmp_live);
    case (mode)
      WM_PHASE:  nxt = ((rising && !at_max) || (!rising && (cnt == '0))) ? cnt + ONE : cnt - ONE;
      WM_CLRCMP: nxt = hit ? '0 : cnt + ONE;
      default:   nxt = cnt + ONE;
    endcase
    ovf_evt = tick_ok && ((mode == WM_PHASE) ? (nxt == '0) : at_max);
    top_evt = tick_ok && (mode == WM_PHASE) && (nxt == MAXV);
    bot_evt = tick_ok && (mode == WM_FAST) && at_max;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
      sup_q  <= 1'b0;
      ovf_q  <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      ovf_q <= ovf_evt;
      cmp_q <= hit;
      if (cnt_wr) begin
        cnt   <= wr_data;
        sup_q <= 1'b1;
      end else if (tick_ok) begin
        cnt   <= nxt;
        sup_q <= 1'b0;
        if (mode == WM_PHASE) begin
          if (nxt == MAXV) rising <= 1'b0;
          else if (nxt == '0) rising <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wt_wave.sv
module wt_wave import wt_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  wt_mode_e   mode,
  input  logic [1:0] act,
  input  logic       hit,
  input  logic       rising,
  input  logic       bot_evt,
  input  logic       force_stb,
  input  logic [1:0] force_act,
  output logic       wave
);
  function automatic logic apply_act(logic [1:0] a, logic cur);
    case (a)
      2'b01:   return !cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  logic nxt;

  always_comb begin
    nxt = wave;
    if (force_stb) begin
      nxt = apply_act(force_act, wave);
    end else begin
      case (mode)
        WM_NORMAL, WM_CLRCMP: if (hit) nxt = apply_act(act, wave);
        WM_FAST: if (act[1]) begin
          if (bot_evt) nxt = !act[0];
          else if (hit) nxt = act[0];
        end
        WM_PHASE: if (act[1] && hit) nxt = rising ? act[0] : !act[0];
        default: nxt = wave;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= nxt;
  end
endmodule

// File: rtl/wavetimer.sv
module wavetimer import wt_pkg::*; #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [1:0]       rd_addr,
  output logic [W-1:0]     rd_data,
  input  logic [NTICK-1:0] tick_in,
  input  logic             dir_en,
  output logic             wave_out,
  output logic             wave_own,
  output logic             pin_en,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  wt_mode_e       mode_w;
  logic [1:0]     mode_bits;
  logic [1:0]     act_w;
  logic [CSW-1:0] csel_w;
  logic           force_stb;
  logic [1:0]     force_act;
  logic           cnt_wr;
  logic [W-1:0]   cmp_buf;
  logic [W-1:0]   cmp_live;
  logic [W-1:0]   cnt_q;
  logic           rising;
  logic           hit;
  logic           top_evt;
  logic           bot_evt;

  wt_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .top_evt(top_evt), .bot_evt(bot_evt), .mode(mode_w), .act(act_w), .csel(csel_w),
    .force_stb(force_stb), .force_act(force_act), .cnt_wr(cnt_wr),
    .cmp_buf(cmp_buf), .cmp_live(cmp_live)
  );

  wt_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .csel(csel_w), .tick_in(tick_in),
    .cnt_wr(cnt_wr), .wr_data(wr_data), .cmp_live(cmp_live), .cnt(cnt_q),
    .rising(rising), .hit(hit), .top_evt(top_evt), .bot_evt(bot_evt),
    .ovf_q(ovf_flag), .cmp_q(cmp_flag)
  );

  wt_wave u_wave (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .act(act_w), .hit(hit), .rising(rising),
    .bot_evt(bot_evt), .force_stb(force_stb), .force_act(force_act), .wave(wave_out)
  );

  always_comb begin
    mode_bits = mode_w;
    wave_own  = (act_w != 2'b00);
    pin_en    = wave_own && dir_en;
    rd_data   = '0;
    case (rd_addr)
      A_CTL:   rd_data[7:0] = {1'b0, mode_bits[0], act_w, mode_bits[1], csel_w};
      A_CNT:   rd_data = cnt_q;
      A_CMP:   rd_data = cmp_buf;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wavetimer_chk.sv
module wavetimer_chk import wt_pkg::*; #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [1:0]     wr_addr,
  input logic [W-1:0]   wr_data,
  input logic [1:0]     mode,
  input logic [CSW-1:0] csel,
  input logic [W-1:0]   cnt,
  input logic           wave_own,
  input logic           dir_en,
  input logic           pin_en,
  input logic           ovf_flag,
  input logic           cmp_flag
);
  logic cnt_write;
  assign cnt_write = wr_en && (wr_addr == A_CNT);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt == '0) && !ovf_flag && !cmp_flag && (csel == '0));

  a_r9_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pin_en |-> (wave_own && dir_en));

  a_r10_halted: assert property (@(posedge clk) disable iff (!rst_n)
    ((csel == '0) && !cnt_write) |=> (cnt == $past(cnt)));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_write |=> (cnt == $past(wr_data)));

  a_r11_no_match_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_write |=> !cmp_flag);

  a_r12_match_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag |-> ($past(csel) != '0));

  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1) && ($past(mode) == 2'd1) && !$past(cnt_write)) |->
      ((cnt == $past(cnt)) || (W'(cnt - $past(cnt)) == W'(1)) || (W'($past(cnt) - cnt) == W'(1))));
endmodule

bind wavetimer wavetimer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mode(mode_bits), .csel(csel_w), .cnt(cnt_q), .wave_own(wave_own), .dir_en(dir_en),
  .pin_en(pin_en), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
);

// File: tb/wavetimer_test.sv
module wavetimer_test;
  localparam int NV = 44;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd1;
  logic [7:0] rd_data;
  logic [6:0] tick_in = 7'd0;
  logic       dir_en = 1'b0;
  logic       wave_out, wave_own, pin_en, ovf_flag, cmp_flag;
  int         nchk = 0;
  int         nfail = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  wavetimer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_in(tick_in), .dir_en(dir_en),
    .wave_out(wave_out), .wave_own(wave_own), .pin_en(pin_en),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  // {wr, addr, data, tick | exp count, exp ovf, exp cmp, exp wave}
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,2'd0,8'h11,1'b0, 8'h00,1'b0,1'b0,1'b0},
    {1'b1,2'd2,8'h02,1'b0, 8'h00,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'h01,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'h02,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'h03,1'b0,1'b1,1'b1},
    {1'b0,2'd0,8'h00,1'b0, 8'h03,1'b0,1'b0,1'b1},
    {1'b1,2'd1,8'hFE,1'b0, 8'hFE,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'hFF,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h00,1'b1,1'b0,1'b1},
    {1'b1,2'd1,8'h02,1'b1, 8'h02,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h03,1'b0,1'b0,1'b1},
    {1'b1,2'd0,8'h91,1'b0, 8'h03,1'b0,1'b0,1'b0},
    {1'b1,2'd0,8'h39,1'b0, 8'h03,1'b0,1'b0,1'b0},
    {1'b1,2'd1,8'h00,1'b0, 8'h00,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'h01,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'h02,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'h00,1'b0,1'b1,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h01,1'b0,1'b0,1'b1},
    {1'b1,2'd0,8'hA9,1'b1, 8'h02,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'h00,1'b0,1'b1,1'b0},
    {1'b1,2'd0,8'h69,1'b0, 8'h00,1'b0,1'b0,1'b0},
    {1'b1,2'd2,8'h03,1'b0, 8'h00,1'b0,1'b0,1'b0},
    {1'b1,2'd1,8'hFE,1'b0, 8'hFE,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'hFF,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'h00,1'b1,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h01,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h02,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h03,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h04,1'b0,1'b1,1'b0},
    {1'b1,2'd0,8'h61,1'b0, 8'h04,1'b0,1'b0,1'b0},
    {1'b1,2'd2,8'hFE,1'b0, 8'h04,1'b0,1'b0,1'b0},
    {1'b1,2'd1,8'hFC,1'b0, 8'hFC,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'hFD,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'hFE,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'hFF,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'hFE,1'b0,1'b0,1'b0},
    {1'b0,2'd0,8'h00,1'b1, 8'hFD,1'b0,1'b1,1'b1},
    {1'b1,2'd1,8'h02,1'b0, 8'h02,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h01,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h00,1'b1,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h01,1'b0,1'b0,1'b1},
    {1'b1,2'd0,8'hE1,1'b0, 8'h01,1'b0,1'b0,1'b1},
    {1'b1,2'd0,8'h60,1'b0, 8'h01,1'b0,1'b0,1'b1},
    {1'b0,2'd0,8'h00,1'b1, 8'h01,1'b0,1'b0,1'b1}
  };

  function automatic string vtag(int i);
    if (i < 11)      return "R3 R7 R11 R12 free-running";
    else if (i < 12) return "R8 force toggle";
    else if (i < 20) return "R4 R7 R8 clear-on-compare";
    else if (i < 29) return "R5 single-slope PWM";
    else if (i < 41) return "R6 phase-correct PWM";
    else if (i < 42) return "R8 force ignored in PWM";
    else             return "R10 clock stopped";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00; tick_in = 7'd0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [22:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd_addr = 2'd1; #0.5;
    check("R1 reset count", rd_data, 8'h00);
    check("R1 reset outputs", {wave_out, wave_own, pin_en, ovf_flag, cmp_flag}, 5'b0);
    rd_addr = 2'd0; #0.5;
    check("R1 reset control", rd_data, 8'h00);
    rd_addr = 2'd1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      wr_en   = v[22];
      wr_addr = v[21:20];
      wr_data = v[19:12];
      tick_in = v[11] ? 7'b0000001 : 7'b0000000;
      cycle();
      check(vtag(i), {21'd0, rd_data, ovf_flag, cmp_flag, wave_out}, {21'd0, v[10:0]});
    end
    idle();

    // R2 control readback, force bit reads 0
    rd_addr = 2'd0; #0.5;
    check("R2 control readback", rd_data, 8'h60);
    // R8 force clear in clear-on-compare mode: no flag, no counter clear
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'hA9;
    cycle();
    idle();
    check("R8 force clears output", wave_out, 1'b0);
    check("R8 force raises no match", cmp_flag, 1'b0);
    check("R2 force bit reads zero", rd_data, 8'h29);
    rd_addr = 2'd1; #0.5;
    check("R8 force keeps count", rd_data, 8'h01);

    // R9 pin ownership and drive
    dir_en = 1'b1; #0.5;
    check("R9 owned and enabled", {wave_own, pin_en}, 2'b11);
    dir_en = 1'b0; #0.5;
    check("R9 direction gates pin", {wave_own, pin_en}, 2'b10);
    dir_en = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h0A;
    cycle();
    idle();
    check("R9 action 00 releases pin", {wave_own, pin_en}, 2'b00);

    // R10 clock select 2 uses tick_in[1] only
    tick_in = 7'b0000001;
    cycle();
    check("R10 unselected tick ignored", rd_data, 8'h01);
    tick_in = 7'b0000010;
    cycle();
    idle();
    check("R10 selected tick counts", rd_data, 8'h02);

    // R1 reset mid-run
    rst_n = 1'b0;
    cycle();
    rst_n = 1'b1;
    rd_addr = 2'd1; #0.5;
    check("R1 reset clears count", rd_data, 8'h00);
    rd_addr = 2'd2; #0.5;
    check("R1 reset clears compare", rd_data, 8'h00);
    rd_addr = 2'd0; #0.5;
    check("R1 reset clears control", rd_data, 8'h00);
    check("R1 reset clears wave", {wave_out, wave_own}, 2'b00);

    done = 1'b1;
    report();
    $finish;
  end
endmodule